// File: doc/BRIEF.md
# Flash Operation Status Bit Generator

This block sits on the device side of a parallel NOR-style flash. It produces the active-low busy indication and the two toggle status bits that a host polls while an embedded program or erase is running. An embedded-operation sequencer supplies start, done, suspend and resume events. The block also receives a per-sector erase-selection mask, a per-sector protection mask, and the address and strobe of each read. From these it decides, on every read, whether to return array data or a status word.

Toggle bit 6 reports the device mode. It inverts on every read while a program or erase is active, and it freezes in erase suspend. Toggle bit 2 reports sector membership. It inverts only on reads that land in a sector being erased, and it does so both while the erase is active and while it is suspended.

Some commands target only protected sectors. These produce a timed false-busy window instead of an operation. The window is about 1 µs for a program and about 100 µs for an erase, and it is counted in clocks of a parameterized frequency.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, busy_n_o is 1 and rd_data_o is 0.
- R2: A program start to an unprotected sector drives busy_n_o to 0 from the next cycle until op_done_i. During that time each read returns bit 6 alternating, with the first read after the command giving 0. After op_done_i, reads return array data.
- R3: An erase start with at least one selected unprotected sector drives busy_n_o to 0 and sets bit 6 inverting on every read. Bit 2 inverts only on reads in the erase set, where the sector index is the top log2(NUM_SECTORS) address bits.
- R4: Suspend during an erase sets busy_n_o to 1. Reads inside the erase set return status with bit 6 held and bit 2 inverting. Reads outside the erase set return array_data_i unchanged.
- R5: A program start to an unprotected sector during suspend drives busy_n_o to 0 and bit 6 inverts per read. op_done_i returns the block to suspend, and resume returns it to the active erase.
- R6: A program start to a protected sector holds busy_n_o at 0 for exactly CLK_MHZ*PROG_US cycles, with bit 6 inverting per read. The block then returns to array read.
- R7: An erase start whose selected sectors are all protected holds busy_n_o at 0 for exactly CLK_MHZ*ERASE_US cycles. During that window bit 2 never inverts.
- R8: Protected sectors in a partly protected erase selection are left out of the erase set, so reads in them never invert bit 2.
- R9: Every accepted start, suspend or resume clears both toggle bits to 0.
- R10: When not busy and not suspended, reads return array_data_i unchanged. Start commands that arrive while busy are ignored and clear nothing.
- R11: rd_data_o is registered. It changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_start_i | input | 1 | Program command sequence completed (one-cycle pulse) |
| prog_addr_i | input | ADDR_W | Target address of the program |
| erase_start_i | input | 1 | Erase command sequence completed (one-cycle pulse) |
| erase_sel_i | input | NUM_SECTORS | Sectors chosen for erase |
| protect_i | input | NUM_SECTORS | Sector protection mask |
| suspend_i | input | 1 | Erase suspend command |
| resume_i | input | 1 | Erase resume command |
| op_done_i | input | 1 | Sequencer reports the running algorithm finished |
| rd_strobe_i | input | 1 | One-cycle read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | DATA_W | Array data for the read address |
| busy_n_o | output | 1 | Busy indication, 0 while busy |
| rd_data_o | output | DATA_W | Read data or status word |

## Verification
The bench builds the block with NUM_SECTORS=4, ADDR_W=8, DATA_W=8, CLK_MHZ=4, PROG_US=1 and ERASE_US=5. With these values the false-busy windows last only 4 and 20 cycles, so both can be measured to the exact cycle within a short run. Four sectors are enough to cover three cases at once: a sector in the erase set, a protected sector that drops out of the set, and an outside sector that a suspend-time program targets.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [2:0] {
    M_IDLE, M_PROG, M_ERASE, M_SUSP, M_SUSP_PROG, M_GUARD
  } mode_e;

  function automatic logic mode_busy(mode_e m);
    return (m == M_PROG) || (m == M_ERASE) || (m == M_SUSP_PROG) || (m == M_GUARD);
  endfunction
endpackage

// File: rtl/fsg_guard_timer.sv
module fsg_guard_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CNT_W'(1));

  // window never runs on an empty count
  p_guard_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q != '0);
endmodule

// File: rtl/fsg_toggle_bits.sv
module fsg_toggle_bits (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic flip6_i,
  input  logic flip2_i,
  output logic dq6_o,
  output logic dq2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq6_o <= 1'b0;
      dq2_o <= 1'b0;
    end else if (clr_i) begin
      dq6_o <= 1'b0;
      dq2_o <= 1'b0;
    end else begin
      if (flip6_i) dq6_o <= ~dq6_o;
      if (flip2_i) dq2_o <= ~dq2_o;
    end
  end

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !dq6_o && !dq2_o);
endmodule

// File: rtl/fsg_mode_ctrl.sv
module fsg_mode_ctrl
  import flash_status_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SEC_W       = 3,
  parameter int CNT_W       = 8,
  parameter int PROG_CYC    = 4,
  parameter int ERASE_CYC   = 100
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   prog_start_i,
  input  logic [SEC_W-1:0]       prog_sect_i,
  input  logic                   erase_start_i,
  input  logic [NUM_SECTORS-1:0] erase_sel_i,
  input  logic [NUM_SECTORS-1:0] protect_i,
  input  logic                   suspend_i,
  input  logic                   resume_i,
  input  logic                   op_done_i,
  input  logic                   expire_i,
  output mode_e                  mode_o,
  output logic [NUM_SECTORS-1:0] mask_o,
  output logic                   cmd_o,
  output logic                   load_o,
  output logic [CNT_W-1:0]       load_val_o
);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC);

  mode_e                  mode_q, mode_d;
  logic [NUM_SECTORS-1:0] mask_q, mask_d, live_sel;

  assign live_sel = erase_sel_i & ~protect_i;

  always_comb begin
    mode_d     = mode_q;
    mask_d     = mask_q;
    cmd_o      = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (mode_q)
      M_IDLE: begin
        if (erase_start_i) begin
          cmd_o = 1'b1;
          if (live_sel == '0) begin
            mode_d     = M_GUARD;
            mask_d     = '0;
            load_o     = 1'b1;
            load_val_o = ERASE_LD;
          end else begin
            mode_d = M_ERASE;
            mask_d = live_sel;
          end
        end else if (prog_start_i) begin
          cmd_o = 1'b1;
          if (protect_i[prog_sect_i]) begin
            mode_d     = M_GUARD;
            load_o     = 1'b1;
            load_val_o = PROG_LD;
          end else begin
            mode_d = M_PROG;
          end
        end
      end
      M_PROG: if (op_done_i) mode_d = M_IDLE;
      M_ERASE: begin
        if (op_done_i) begin
          mode_d = M_IDLE;
          mask_d = '0;
        end else if (suspend_i) begin
          mode_d = M_SUSP;
          cmd_o  = 1'b1;
        end
      end
      M_SUSP: begin
        if (resume_i) begin
          mode_d = M_ERASE;
          cmd_o  = 1'b1;
        end else if (prog_start_i && !protect_i[prog_sect_i]) begin
          mode_d = M_SUSP_PROG;
          cmd_o  = 1'b1;
        end
      end
      M_SUSP_PROG: if (op_done_i) mode_d = M_SUSP;
      M_GUARD:     if (expire_i)  mode_d = M_IDLE;
      default:     mode_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_IDLE;
      mask_q <= '0;
    end else begin
      mode_q <= mode_d;
      mask_q <= mask_d;
    end
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;

  // a false-busy window never carries an erase set
  p_guard_no_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == M_GUARD |-> mask_q == '0);
  // erase set never holds a protected sector at latch time
  p_set_unprot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_IDLE && erase_start_i) |=> (mask_q & $past(protect_i)) == '0);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CLK_MHZ     = 250,
  parameter int PROG_US     = 1,
  parameter int ERASE_US    = 100
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   prog_start_i,
  input  logic [ADDR_W-1:0]      prog_addr_i,
  input  logic                   erase_start_i,
  input  logic [NUM_SECTORS-1:0] erase_sel_i,
  input  logic [NUM_SECTORS-1:0] protect_i,
  input  logic                   suspend_i,
  input  logic                   resume_i,
  input  logic                   op_done_i,
  input  logic                   rd_strobe_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic [DATA_W-1:0]      array_data_i,
  output logic                   busy_n_o,
  output logic [DATA_W-1:0]      rd_data_o
);
  localparam int SEC_W     = $clog2(NUM_SECTORS);
  localparam int PROG_CYC  = CLK_MHZ * PROG_US;
  localparam int ERASE_CYC = CLK_MHZ * ERASE_US;
  localparam int MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  mode_e                  mode;
  logic [NUM_SECTORS-1:0] mask;
  logic                   cmd, load, expire, dq6, dq2;
  logic [CNT_W-1:0]       load_val;
  logic [SEC_W-1:0]       rd_sect, prog_sect;
  logic                   busy, hit, status_rd, flip6, flip2;
  logic [DATA_W-1:0]      status_word, rd_data_q;

  assign rd_sect   = rd_addr_i[ADDR_W-1 -: SEC_W];
  assign prog_sect = prog_addr_i[ADDR_W-1 -: SEC_W];
  assign busy      = mode_busy(mode);
  assign hit       = mask[rd_sect];
  assign status_rd = busy || (mode == M_SUSP && hit);
  assign flip6     = rd_strobe_i && busy;
  assign flip2     = rd_strobe_i && hit &&
                     (mode == M_ERASE || mode == M_SUSP || mode == M_SUSP_PROG);

  fsg_mode_ctrl #(
    .NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W), .CNT_W(CNT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_mode (
    .clk_i, .rst_ni, .prog_start_i, .prog_sect_i(prog_sect),
    .erase_start_i, .erase_sel_i, .protect_i, .suspend_i, .resume_i,
    .op_done_i, .expire_i(expire), .mode_o(mode), .mask_o(mask),
    .cmd_o(cmd), .load_o(load), .load_val_o(load_val)
  );

  fsg_guard_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .run_i(mode == M_GUARD), .expire_o(expire)
  );

  fsg_toggle_bits u_tog (
    .clk_i, .rst_ni, .clr_i(cmd), .flip6_i(flip6), .flip2_i(flip2),
    .dq6_o(dq6), .dq2_o(dq2)
  );

  always_comb begin
    status_word    = array_data_i;
    status_word[6] = dq6;
    status_word[2] = dq2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rd_data_q <= '0;
    else if (rd_strobe_i) rd_data_q <= status_rd ? status_word : array_data_i;
  end

  assign rd_data_o = rd_data_q;
  assign busy_n_o  = ~busy;

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_strobe_i |=> $stable(rd_data_o));
  p_array_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && busy_n_o && !(mode == M_SUSP && hit)) |=> rd_data_o == $past(array_data_i));
endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  localparam int NS = 4, AW = 8, DW = 8, MHZ = 4, PUS = 1, EUS = 5;
  localparam int SH = 6;
  localparam int PN = MHZ * PUS, EN = MHZ * EUS;

  logic clk = 0, rst_n = 0;
  logic prog_start = 0, erase_start = 0, suspend = 0, resume = 0, op_done = 0, rd_strobe = 0;
  logic [AW-1:0] prog_addr = 0, rd_addr = 0;
  logic [NS-1:0] erase_sel = 0, protect = 0;
  logic [DW-1:0] array_data = 8'h3C;
  logic busy_n;
  logic [DW-1:0] rd_data;

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  flash_status_gen #(.NUM_SECTORS(NS), .ADDR_W(AW), .DATA_W(DW),
    .CLK_MHZ(MHZ), .PROG_US(PUS), .ERASE_US(EUS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(prog_start), .prog_addr_i(prog_addr),
    .erase_start_i(erase_start), .erase_sel_i(erase_sel), .protect_i(protect),
    .suspend_i(suspend), .resume_i(resume), .op_done_i(op_done),
    .rd_strobe_i(rd_strobe), .rd_addr_i(rd_addr), .array_data_i(array_data),
    .busy_n_o(busy_n), .rd_data_o(rd_data));

  // behavioural reference: 0 idle,1 prog,2 erase,3 susp,4 susp prog,5 guard
  int mm, mcnt, nm, s, ps;
  bit [NS-1:0] mmask;
  bit m6, m2, hit, bsy, stat, clr;
  logic [DW-1:0] xdata;

  function automatic bit is_busy(int m);
    return m == 1 || m == 2 || m == 4 || m == 5;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm = 0; mmask = 0; mcnt = 0; m6 = 0; m2 = 0; xdata = 0;
    end else begin
      s = int'(rd_addr) >> SH; ps = int'(prog_addr) >> SH;
      hit = mmask[s]; bsy = is_busy(mm); stat = bsy || (mm == 3 && hit);
      if (rd_strobe) begin
        xdata = array_data;
        if (stat) begin xdata[6] = m6; xdata[2] = m2; end
      end
      clr = 0; nm = mm;
      case (mm)
        0: if (erase_start) begin
             clr = 1;
             if ((erase_sel & ~protect) == 0) begin nm = 5; mcnt = EN; mmask = 0; end
             else begin nm = 2; mmask = erase_sel & ~protect; end
           end else if (prog_start) begin
             clr = 1;
             if (protect[ps]) begin nm = 5; mcnt = PN; end else nm = 1;
           end
        1: if (op_done) nm = 0;
        2: if (op_done) begin nm = 0; mmask = 0; end
           else if (suspend) begin nm = 3; clr = 1; end
        3: if (resume) begin nm = 2; clr = 1; end
           else if (prog_start && !protect[ps]) begin nm = 4; clr = 1; end
        4: if (op_done) nm = 3;
        default: begin mcnt--; if (mcnt == 0) nm = 0; end
      endcase
      if (clr) begin m6 = 0; m2 = 0; end
      else begin
        if (rd_strobe && bsy) m6 = ~m6;
        if (rd_strobe && hit && (mm == 2 || mm == 3 || mm == 4)) m2 = ~m2;
      end
      mm = nm;
    end
  end

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk(cur_req, busy_n, is_busy(mm) ? 0 : 1);
    chk(cur_req, rd_data, xdata);
  end

  task automatic pulse(ref logic sig);
    @(posedge clk); #1 sig = 1;
    @(posedge clk); #1 sig = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(posedge clk); #1 rd_addr = a; rd_strobe = 1;
    @(posedge clk); #1 rd_strobe = 0;
    @(negedge clk); d = rd_data;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (busy_n == 0) n++; else break;
    end
  endtask

  task automatic wait_ready();
    while (busy_n == 0) @(negedge clk);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got hang expected completion");
    finish_up();
  end

  initial begin
    logic [DW-1:0] d;
    int n;
    #1;
    @(negedge clk);
    chk("R1", busy_n, 1); chk("R1", rd_data, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;

    cur_req = "R10";
    rd(8'h40, d); chk("R10", d, 8'h3C);

    cur_req = "R2";
    prog_addr = 8'h40;
    pulse(prog_start);
    @(negedge clk); chk("R2", busy_n, 0);
    rd(8'h40, d); chk("R2", d[6], 0);
    rd(8'h00, d); chk("R2", d[6], 1);
    rd(8'hC0, d); chk("R2", d[6], 0);
    cur_req = "R10";
    pulse(prog_start);
    rd(8'h40, d); chk("R10", d[6], 1);
    cur_req = "R2";
    pulse(op_done);
    @(negedge clk); chk("R2", busy_n, 1);
    rd(8'h40, d); chk("R2", d, 8'h3C);

    cur_req = "R3";
    erase_sel = 4'b0110; protect = 4'b0100;
    pulse(erase_start);
    @(negedge clk); chk("R3", busy_n, 0);
    rd(8'h40, d); chk("R3", d[6], 0); chk("R3", d[2], 0);
    rd(8'h40, d); chk("R3", d[6], 1); chk("R3", d[2], 1);
    cur_req = "R8";
    rd(8'h80, d); chk("R8", d[6], 0); chk("R8", d[2], 0);
    rd(8'h80, d); chk("R8", d[6], 1); chk("R8", d[2], 0);

    cur_req = "R4";
    pulse(suspend);
    @(negedge clk); chk("R4", busy_n, 1);
    rd(8'h40, d); chk("R4", d[6], 0); chk("R4", d[2], 0);
    rd(8'h40, d); chk("R4", d[6], 0); chk("R4", d[2], 1);
    rd(8'hC0, d); chk("R4", d, 8'h3C);

    cur_req = "R5";
    prog_addr = 8'hC0;
    pulse(prog_start);
    @(negedge clk); chk("R5", busy_n, 0);
    rd(8'hC0, d); chk("R5", d[6], 0);
    rd(8'hC0, d); chk("R5", d[6], 1);
    pulse(op_done);
    @(negedge clk); chk("R5", busy_n, 1);
    rd(8'h40, d); chk("R5", d[6], 0);
    rd(8'h40, d); chk("R5", d[6], 0);

    cur_req = "R9";
    pulse(resume);
    @(negedge clk); chk("R9", busy_n, 0);
    rd(8'h40, d); chk("R9", d[6], 0); chk("R9", d[2], 0);
    pulse(op_done);
    rd(8'h40, d); chk("R3", d, 8'h3C);

    cur_req = "R6";
    protect = 4'b0001; prog_addr = 8'h00;
    @(posedge clk); #1 prog_start = 1;
    @(posedge clk); #1 prog_start = 0;
    busy_len(n); chk("R6", n, PN);
    pulse(prog_start);
    rd(8'h00, d); chk("R6", d[6], 0);
    wait_ready();
    rd(8'h00, d); chk("R6", d, 8'h3C);

    cur_req = "R7";
    erase_sel = 4'b0001;
    @(posedge clk); #1 erase_start = 1;
    @(posedge clk); #1 erase_start = 0;
    busy_len(n); chk("R7", n, EN);
    pulse(erase_start);
    rd(8'h00, d); chk("R7", d[6], 0); chk("R7", d[2], 0);
    rd(8'h00, d); chk("R7", d[6], 1); chk("R7", d[2], 0);
    wait_ready();

    cur_req = "R11";
    rd(8'h80, d); chk("R11", d, 8'h3C);
    #1 array_data = 8'h55;
    repeat (3) @(negedge clk);
    chk("R11", rd_data, 8'h3C);
    rd(8'h80, d); chk("R11", d, 8'h55);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule